// File: doc/BRIEF.md
# Power-Pulsed Token-Ring Readout Sequencer

This block runs a chain of front-end readout chips through a repeating three-phase cycle. The phases are acquisition, readout and idle, in that order. It also switches three independent power-enable lines (analog, ADC, digital) so that the front-end electronics draw current only for the small fraction of each cycle in which they do useful work. The phase lengths are parameters counted in clock cycles. The long idle phase dominates, so the duty cycle of the powered phases stays near one percent.

During readout a single grant, the token, walks along the daisy chain. It starts at chip 0 and visits each chip in chain order, so only one chip at a time may drive the shared data bus. A chip keeps the token until it signals done. A chip that reports no events passes the token after one cycle. A per-chip watchdog stops a stuck chip from holding the token forever, and a sticky flag records that this happened. Readout ends as soon as the last chip finishes, or when the readout budget runs out, whichever comes first.

After reset the block waits in idle until a start pulse arrives. From then on it repeats the cycle by itself.

Top module: `pulse_ring_seq`

## Requirements
- R1: While reset is asserted and after it, before any start, phase_o is 0 (idle), all three power enables are low, no token bit is set and tok_err_o is low.
- R2: After reset the block stays idle for as long as start_i is low. A start_i pulse seen in idle moves phase_o to 1 (acquisition) on the next clock.
- R3: The phases run in the order acquisition (1), readout (2), idle (0), and then acquisition again without any further start. Acquisition lasts exactly ACQ_CYC cycles and idle lasts exactly IDLE_CYC cycles.
- R4: In acquisition all three power enables are high. In readout the ADC and digital enables are high and the analog enable is low. In idle all three are low.
- R5: At most one bit of tok_o is set, and only during readout. The first chip granted is chip 0, and the granted index never decreases within one readout.
- R6: The token leaves a chip at the first clock edge at which that chip's done input is high. A chip whose done rises during its k-th granted cycle holds the token for exactly k cycles.
- R7: A chip whose event-present input is low while it holds the token keeps it for exactly one cycle, whatever its done input does.
- R8: When the last chip (index N_CHIPS-1) releases the token, readout ends and phase_o is 0 on the next cycle. The readout length is then the sum of the per-chip hold times.
- R9: Readout lasts at most RO_CYC cycles. When that budget is spent, the block enters idle whichever chip holds the token, and the remaining chips get no grant.
- R10: A chip that has events and has held the token for TMO_CYC cycles without done loses the token. tok_err_o then goes high and stays high until reset. A done arriving in the TMO_CYC-th cycle does not set the flag.
- R11: Asserting reset in the middle of a cycle returns all outputs to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts the first cycle after reset |
| chip_done_i | input | N_CHIPS | Per-chip readout-finished signal, valid while granted |
| chip_evt_i | input | N_CHIPS | Per-chip event-present signal |
| pwr_ana_o | output | 1 | Analog power-pulse enable |
| pwr_adc_o | output | 1 | ADC power-pulse enable |
| pwr_dig_o | output | 1 | Digital power-pulse enable |
| tok_o | output | N_CHIPS | One-hot token grant per chip |
| phase_o | output | 2 | 0 idle, 1 acquisition, 2 readout |
| tok_err_o | output | 1 | Sticky token-watchdog error flag |

## Verification
The bench drives a four-chip chain through several readouts with reactive chip models, and measures every grant length and phase length cycle by cycle. The corner cases it targets are these:
- Zero-event chips. A design that waits for done on such a chip would stretch its grant.
- A done arriving exactly at the watchdog limit. An off-by-one here would set the error flag falsely or grant one cycle too many.
- The readout budget expiring mid-chip. A design that ignores the budget would keep granting the later chips.
- A stuck chip. It must be skipped, and the flag must survive the following clean cycles; a non-sticky flag would drop back low.

It also checks that the analog line is off during readout and that idle needs no new start.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  localparam int NUM_LINES = 3;
  localparam int LINE_ANA  = 0;
  localparam int LINE_ADC  = 1;
  localparam int LINE_DIG  = 2;

  // Which power lines each phase keeps on, indexed by LINE_*.
  function automatic logic [NUM_LINES-1:0] line_mask(input phase_e ph);
    logic [NUM_LINES-1:0] m;
    m = '0;
    if (ph == PH_ACQ) begin
      m = '1;
    end else if (ph == PH_READ) begin
      m[LINE_ADC] = 1'b1;
      m[LINE_DIG] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pulse_phase_ctrl.sv
module pulse_phase_ctrl
  import pulse_seq_pkg::*;
#(
  parameter int ACQ_CYC  = 40000,
  parameter int RO_CYC   = 20000,
  parameter int IDLE_CYC = 7920000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   ring_end_i,
  output phase_e phase_o,
  output phase_e phase_nxt_o
);

  localparam int MAX_A = (ACQ_CYC > RO_CYC) ? ACQ_CYC : RO_CYC;
  localparam int MAX_C = (MAX_A > IDLE_CYC) ? MAX_A : IDLE_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            run_q, run_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    run_d   = run_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (!run_q) begin
          cnt_d = '0;
          if (start_i) begin
            phase_d = PH_ACQ;
            run_d   = 1'b1;
          end
        end else if (cnt_q == CW'(IDLE_CYC - 1)) begin
          phase_d = PH_ACQ;
          cnt_d   = '0;
        end
      end
      PH_ACQ: begin
        if (cnt_q == CW'(ACQ_CYC - 1)) begin
          phase_d = PH_READ;
          cnt_d   = '0;
        end
      end
      PH_READ: begin
        if (ring_end_i || cnt_q == CW'(RO_CYC - 1)) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
    end
  end

  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_d;

  // R3
  acq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACQ) |=> (phase_q == PH_ACQ || phase_q == PH_READ));
  // R3
  read_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ) |=> (phase_q == PH_READ || phase_q == PH_IDLE));
  // R2
  idle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> (phase_q == PH_IDLE || phase_q == PH_ACQ));
  // R8
  ring_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ && ring_end_i) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/pulse_token_ring.sv
module pulse_token_ring
  import pulse_seq_pkg::*;
#(
  parameter int N_CHIPS = 24,
  parameter int TMO_CYC = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase_i,
  input  logic [N_CHIPS-1:0] done_i,
  input  logic [N_CHIPS-1:0] evt_i,
  output logic [N_CHIPS-1:0] tok_o,
  output logic               ring_end_o,
  output logic               err_o
);

  localparam int IW = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1;
  localparam int HW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

  logic [IW-1:0] idx_q, idx_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          err_q, err_d;
  logic          in_rd, cur_done, cur_evt, tmo, adv, last;

  always_comb begin
    in_rd    = (phase_i == PH_READ);
    cur_done = done_i[idx_q];
    cur_evt  = evt_i[idx_q];
    tmo      = (hold_q == HW'(TMO_CYC - 1));
    adv      = in_rd && (cur_done || !cur_evt || tmo);
    last     = (idx_q == IW'(N_CHIPS - 1));

    idx_d  = idx_q;
    hold_d = hold_q + 1'b1;
    err_d  = err_q;
    if (!in_rd) begin
      idx_d  = '0;
      hold_d = '0;
    end else if (adv) begin
      hold_d = '0;
      if (!last) idx_d = idx_q + 1'b1;
      if (tmo && cur_evt && !cur_done) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hold_q <= '0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_grant
    assign tok_o[g] = in_rd && (idx_q == IW'(g));
  end

  assign ring_end_o = adv && last;
  assign err_o      = err_q;

  // R5
  tok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_o));
  // R5
  tok_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_READ) |-> (tok_o == '0));
  // R5
  tok_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_READ && $past(phase_i) == PH_READ) |-> (idx_q >= $past(idx_q)));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/pulse_power_gate.sv
module pulse_power_gate
  import pulse_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_nxt_i,
  output logic   ana_o,
  output logic   adc_o,
  output logic   dig_o
);

  logic [NUM_LINES-1:0] en_q, en_d;

  assign en_d = line_mask(phase_nxt_i);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[l] <= 1'b0;
      else        en_q[l] <= en_d[l];
    end
  end

  assign ana_o = en_q[LINE_ANA];
  assign adc_o = en_q[LINE_ADC];
  assign dig_o = en_q[LINE_DIG];

  // R4
  ana_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ana_o |-> (adc_o && dig_o));

endmodule

// File: rtl/pulse_ring_seq.sv
module pulse_ring_seq
  import pulse_seq_pkg::*;
#(
  parameter int N_CHIPS  = 24,
  parameter int ACQ_CYC  = 40000,
  parameter int RO_CYC   = 20000,
  parameter int IDLE_CYC = 7920000,
  parameter int TMO_CYC  = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [N_CHIPS-1:0] chip_done_i,
  input  logic [N_CHIPS-1:0] chip_evt_i,
  output logic               pwr_ana_o,
  output logic               pwr_adc_o,
  output logic               pwr_dig_o,
  output logic [N_CHIPS-1:0] tok_o,
  output logic [1:0]         phase_o,
  output logic               tok_err_o
);

  logic   rst_meta_q, rst_sync_q;
  phase_e phase_q, phase_nxt;
  logic   ring_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pulse_phase_ctrl #(
    .ACQ_CYC (ACQ_CYC),
    .RO_CYC  (RO_CYC),
    .IDLE_CYC(IDLE_CYC)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .ring_end_i (ring_end),
    .phase_o    (phase_q),
    .phase_nxt_o(phase_nxt)
  );

  pulse_token_ring #(
    .N_CHIPS(N_CHIPS),
    .TMO_CYC(TMO_CYC)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .phase_i   (phase_q),
    .done_i    (chip_done_i),
    .evt_i     (chip_evt_i),
    .tok_o     (tok_o),
    .ring_end_o(ring_end),
    .err_o     (tok_err_o)
  );

  pulse_power_gate u_power (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .phase_nxt_i(phase_nxt),
    .ana_o      (pwr_ana_o),
    .adc_o      (pwr_adc_o),
    .dig_o      (pwr_dig_o)
  );

  assign phase_o = phase_q;

  // R11
  rst_out_chk: assert property (@(posedge clk)
    (!rst_sync_q) |-> (tok_o == '0 && !tok_err_o && !pwr_ana_o && phase_o == 2'd0));

endmodule

// File: tb/pulse_ring_seq_tb.sv
module pulse_ring_seq_tb;

  localparam int NCH  = 4;
  localparam int ACQ  = 5;
  localparam int RO   = 40;
  localparam int IDLE = 8;
  localparam int TMO  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [NCH-1:0] done = '0;
  logic [NCH-1:0] evt = '1;
  logic           p_ana, p_adc, p_dig, err;
  logic [NCH-1:0] tok;
  logic [1:0]     phase;

  int lat [NCH];
  int gcnt [NCH];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit err_exp = 1'b0;

  always #2.5 clk = ~clk;

  pulse_ring_seq #(
    .N_CHIPS(NCH), .ACQ_CYC(ACQ), .RO_CYC(RO), .IDLE_CYC(IDLE), .TMO_CYC(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .chip_done_i(done), .chip_evt_i(evt),
    .pwr_ana_o(p_ana), .pwr_adc_o(p_adc), .pwr_dig_o(p_dig),
    .tok_o(tok), .phase_o(phase), .tok_err_o(err)
  );

  // Chip models: done rises in the lat-th granted cycle.
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (tok[i]) begin
        gcnt[i] = gcnt[i] + 1;
        done[i] = (gcnt[i] >= lat[i]);
      end else begin
        gcnt[i] = 0;
        done[i] = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_one(input string req);
    int e [NCH];
    int l_got [NCH];
    int rem, l, n, prev, sum_e, rd;
    bit mono, pbad, first_ok;
    rem = RO;
    sum_e = 0;
    for (int i = 0; i < NCH; i++) begin
      l = evt[i] ? ((lat[i] < 1) ? 1 : ((lat[i] < TMO) ? lat[i] : TMO)) : 1;
      if (evt[i] && lat[i] > TMO && TMO <= rem) err_exp = 1'b1;
      e[i] = (l < rem) ? l : rem;
      rem -= e[i];
      sum_e += e[i];
      l_got[i] = 0;
    end
    n = 0;
    while (phase != 2'd1 && n < 200) begin @(negedge clk); n++; end
    n = 0; pbad = 1'b0;
    while (phase == 2'd1 && n < 200) begin
      if (!(p_ana && p_adc && p_dig) || tok != '0) pbad = 1'b1;
      n++; @(negedge clk);
    end
    chk(n == ACQ, "R3", "acquisition length", n, ACQ);
    chk(!pbad, "R4", "acquisition power/tok", pbad, 0);
    prev = -1; mono = 1'b1; first_ok = 1'b1; pbad = 1'b0; rd = 0;
    while (phase == 2'd2 && rd < 200) begin
      if (p_ana || !p_adc || !p_dig) pbad = 1'b1;
      if ($countones(tok) != 1) mono = 1'b0;
      for (int i = 0; i < NCH; i++) begin
        if (tok[i]) begin
          if (prev == -1 && i != 0) first_ok = 1'b0;
          if (i < prev) mono = 1'b0;
          prev = i;
          l_got[i]++;
        end
      end
      rd++; @(negedge clk);
    end
    chk(!pbad, "R4", "readout power", pbad, 0);
    chk(mono && first_ok, "R5", "token order/onehot", mono, 1);
    for (int i = 0; i < NCH; i++)
      chk(l_got[i] == e[i], req, $sformatf("chip %0d hold", i), l_got[i], e[i]);
    chk(rd == sum_e, (sum_e == RO) ? "R9" : "R8", "readout length", rd, sum_e);
    n = 0; pbad = 1'b0;
    while (phase == 2'd0 && n < 200) begin
      if (p_ana || p_adc || p_dig || tok != '0) pbad = 1'b1;
      n++; @(negedge clk);
    end
    chk(n == IDLE, "R3", "idle length", n, IDLE);
    chk(!pbad, "R4", "idle power/tok", pbad, 0);
    chk(err == err_exp, "R10", "error flag", err, err_exp);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin lat[i] = 1; gcnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(phase == 0 && !p_ana && !p_adc && !p_dig && tok == '0 && !err, "R1", "in reset", phase, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(phase == 0 && !p_ana && !p_adc && !p_dig && tok == '0 && !err, "R1", "after reset", phase, 0);
    chk(phase == 0, "R2", "idle without start", phase, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(phase == 1, "R2", "start enters acquisition", phase, 1);
    // Plain holds: R6
    lat = '{1, 3, 2, 4}; evt = 4'b1111;
    run_one("R6");
    // Zero-event chips pass in one cycle: R7
    lat = '{9, 5, 9, 1}; evt = 4'b1010;
    run_one("R7");
    // Budget expires during chip 2: R9
    lat = '{15, 15, 15, 15}; evt = 4'b1111;
    run_one("R9");
    // done exactly at the watchdog limit: R10 no error
    lat = '{16, 1, 1, 1}; evt = 4'b1111;
    run_one("R10");
    // Stuck chip 1 skipped, flag set: R10
    lat = '{2, 25, 1, 1}; evt = 4'b1111;
    run_one("R10");
    // Clean cycle afterwards, flag must stay: R10
    lat = '{1, 3, 2, 4}; evt = 4'b1111;
    run_one("R10");
    // Mid-cycle reset: R11
    while (phase != 2'd2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(phase == 0 && tok == '0 && !err && !p_ana && !p_adc && !p_dig, "R11", "reset mid readout", phase, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(phase == 0 && !err, "R11", "idle after reset", phase, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule